// File: doc/BRIEF.md
# Hardware Unique Key Provisioner

This sequencer sits between one key consumer, a random-number source and the command port of a fuse controller. The consumer raises a request. The block then reads a fixed four-word key slot from the fuse array as a single burst. If every bit of the slot is zero, the slot counts as unprogrammed. In that case the block takes 128 bits from the random source and burns them into the slot, one word per command. It then hands back the 128-bit key together with a one-cycle completion pulse and a status code.

Before each word is programmed, that word is read again on its own. Bits that are already set are left out of the write. A word that is already correct is skipped. A word that would need any bit to go from 1 back to 0 stops the whole sequence with an error. Each fuse command has its own timeout. Fuse errors, verify failures and timeouts end the request at once. The internal key buffer is cleared at the end of every request, whatever the outcome.

Top module: `huk_provisioner`

## Requirements
- R1: During and straight after reset, keyGrant, keyDone, fuseCmdValid and rngReq are low and keyData is zero.
- R2: A request is taken only while the block is idle. keyGrant rises on the cycle after keyReq is seen. The first fuse command is a read (fuseCmdWrite=0) of fuseCmdCount=4 words starting at fuse index 0x104.
- R3: If the burst read returns a non-zero slot, the block finishes with keyStatus=0. keyData equals the slot, with the word at index 0x104 in bits 31:0 and each higher index in the next 32 bits. No random data is requested and no write is issued.
- R4: If the slot reads back all zero, the block requests random data once. It then handles the words in rising index order (0x104+i). Each word gets a one-word read (count 1) followed, when needed, by a one-word write (fuseCmdWrite=1, count 1). The returned key equals the random value and keyStatus=0.
- R5: A write carries only the target bits that are not yet set in the word just read. A word that needs no new bits gets no write command.
- R6: If a target word is missing a bit that the fuse word already has set, the request ends with keyStatus=1 and no further commands are issued.
- R7: A response with fuseRspError on any read, or with fuseRspError or fuseRspVerifyFail on a write, ends the request with keyStatus=1 and no further commands.
- R8: If no response arrives within TIMEOUT_CYCLES cycles after a command, the request ends with keyStatus=2. A response in the last allowed cycle is accepted. The count restarts for every command.
- R9: keyDone lasts exactly one cycle. keyData is non-zero only in that cycle, only when keyStatus=0. A failed request returns zero, and no stale key appears afterwards.
- R10: keyGrant stays high from acceptance through the keyDone cycle and is low for at least one cycle afterwards. A request held high is served again only after that gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyReq | input | 1 | Key request from the consumer |
| keyGrant | output | 1 | High while a request is being served |
| keyDone | output | 1 | One-cycle completion pulse |
| keyStatus | output | 2 | 0 success, 1 fuse/verify/conflict error, 2 timeout |
| keyData | output | 128 | Key, valid only with keyDone and success |
| rngReq | output | 1 | Request for random data |
| rngValid | input | 1 | Random data valid |
| rngData | input | 128 | Random data |
| fuseCmdValid | output | 1 | One-cycle fuse command strobe |
| fuseCmdWrite | output | 1 | 1 write, 0 read |
| fuseCmdIndex | output | 10 | First fuse word index |
| fuseCmdCount | output | 3 | Number of words (4 burst, 1 single) |
| fuseCmdWdata | output | 32 | Bits to program |
| fuseRspValid | input | 1 | Fuse command completed |
| fuseRspError | input | 1 | Fuse command failed |
| fuseRspVerifyFail | input | 1 | Programmed word did not verify |
| fuseRspData | input | 128 | Read data, single-word reads in bits 31:0 |

## Verification
The bench goes after the slot states that steer the sequence. These are a blank slot whose random value holds a zero word, a word partly programmed by someone else between the burst read and its own read, and a word that clashes with the target. A design that rewrote set bits or wrote skipped words would show wrong write data or extra commands. A design that ignored the clash would keep programming. Fuse errors, verify failures and dropped responses are injected at chosen commands, and the bench checks that nothing follows them and that the key stays zero. Response delays that reach the last allowed cycle, and per-command delays whose sum exceeds the limit, catch a timer that is off by one or never restarted.

// File: rtl/huk_pkg.sv
package huk_pkg;
  typedef struct packed {
    logic loadRead;
    logic loadRng;
    logic loadOld;
    logic clearIdx;
    logic nextWord;
    logic startTimer;
    logic clearBuf;
  } hukStrobe_t;

  typedef enum logic [1:0] {
    KEY_OK      = 2'd0,
    KEY_FAIL    = 2'd1,
    KEY_TIMEOUT = 2'd2
  } keyStatus_t;
endpackage

// File: rtl/huk_datapath.sv
module huk_datapath
  import huk_pkg::*;
#(
  parameter int WORDS          = 4,
  parameter int WORD_W         = 32,
  parameter int TIMEOUT_CYCLES = 1000,
  localparam int KEY_W    = WORDS * WORD_W,
  localparam int IDX_BITS = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int TMR_W    = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  hukStrobe_t          strobe,
  input  logic [KEY_W-1:0]    fuseRspData,
  input  logic [KEY_W-1:0]    rngData,
  output logic [KEY_W-1:0]    keyBuf,
  output logic [IDX_BITS-1:0] wordIdx,
  output logic [WORD_W-1:0]   progBits,
  output logic                blank,
  output logic                conflict,
  output logic                noChange,
  output logic                lastWord,
  output logic                timedOut
);
  logic [WORD_W-1:0] oldWord;
  logic [WORD_W-1:0] target;
  logic [TMR_W-1:0]  tmr;

  // key buffer: filled by the burst read or the random source, wiped at end
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearBuf) begin
      keyBuf  <= '0;
      oldWord <= '0;
    end else begin
      if (strobe.loadRead)     keyBuf  <= fuseRspData;
      else if (strobe.loadRng) keyBuf  <= rngData;
      if (strobe.loadOld)      oldWord <= fuseRspData[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearIdx || strobe.clearBuf) wordIdx <= '0;
    else if (strobe.nextWord)                          wordIdx <= wordIdx + IDX_BITS'(1);
  end

  // per-command response timer, saturating
  always_ff @(posedge clk) begin
    if (!rstN || strobe.startTimer)         tmr <= '0;
    else if (tmr != TMR_W'(TIMEOUT_CYCLES)) tmr <= tmr + TMR_W'(1);
  end

  assign target   = keyBuf[wordIdx*WORD_W +: WORD_W];
  assign progBits = target & ~oldWord;
  assign blank    = (keyBuf == '0);
  assign conflict = |(~target & oldWord);
  assign noChange = (progBits == '0);
  assign lastWord = (wordIdx == IDX_BITS'(WORDS - 1));
  assign timedOut = (tmr == TMR_W'(TIMEOUT_CYCLES - 1));
endmodule

// File: rtl/huk_control.sv
module huk_control
  import huk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyReq,
  input  logic       fuseRspValid,
  input  logic       fuseRspError,
  input  logic       fuseRspVerifyFail,
  input  logic       rngValid,
  input  logic       blank,
  input  logic       conflict,
  input  logic       noChange,
  input  logic       lastWord,
  input  logic       timedOut,
  output hukStrobe_t strobe,
  output logic       fuseCmdValid,
  output logic       fuseCmdWrite,
  output logic       fuseCmdSingle,
  output logic       rngReq,
  output logic       keyGrant,
  output logic       keyDone,
  output keyStatus_t keyStatus
);
  typedef enum logic [3:0] {
    S_IDLE, S_BURST, S_BURST_WAIT, S_CHECK, S_RNG,
    S_PEEK, S_PEEK_WAIT, S_CMP, S_PROG, S_PROG_WAIT, S_DONE
  } state_t;

  state_t     state, nextState;
  keyStatus_t statusQ, nextStatus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      statusQ <= KEY_OK;
    end else begin
      state   <= nextState;
      statusQ <= nextStatus;
    end
  end

  always_comb begin
    nextState     = state;
    nextStatus    = statusQ;
    strobe        = '0;
    fuseCmdValid  = 1'b0;
    fuseCmdWrite  = 1'b0;
    fuseCmdSingle = 1'b0;
    rngReq        = 1'b0;
    keyDone       = 1'b0;
    case (state)
      S_IDLE: if (keyReq) nextState = S_BURST;
      S_BURST: begin
        fuseCmdValid      = 1'b1;
        strobe.startTimer = 1'b1;
        nextState         = S_BURST_WAIT;
      end
      S_BURST_WAIT: begin
        if (fuseRspValid) begin
          if (fuseRspError) begin
            nextStatus = KEY_FAIL;
            nextState  = S_DONE;
          end else begin
            strobe.loadRead = 1'b1;
            nextState       = S_CHECK;
          end
        end else if (timedOut) begin
          nextStatus = KEY_TIMEOUT;
          nextState  = S_DONE;
        end
      end
      S_CHECK: begin
        if (blank) nextState = S_RNG;
        else begin
          nextStatus = KEY_OK;
          nextState  = S_DONE;
        end
      end
      S_RNG: begin
        rngReq = 1'b1;
        if (rngValid) begin
          strobe.loadRng  = 1'b1;
          strobe.clearIdx = 1'b1;
          nextState       = S_PEEK;
        end
      end
      S_PEEK: begin
        fuseCmdValid      = 1'b1;
        fuseCmdSingle     = 1'b1;
        strobe.startTimer = 1'b1;
        nextState         = S_PEEK_WAIT;
      end
      S_PEEK_WAIT: begin
        if (fuseRspValid) begin
          if (fuseRspError) begin
            nextStatus = KEY_FAIL;
            nextState  = S_DONE;
          end else begin
            strobe.loadOld = 1'b1;
            nextState      = S_CMP;
          end
        end else if (timedOut) begin
          nextStatus = KEY_TIMEOUT;
          nextState  = S_DONE;
        end
      end
      S_CMP: begin
        if (conflict) begin
          nextStatus = KEY_FAIL;
          nextState  = S_DONE;
        end else if (!noChange) begin
          nextState = S_PROG;
        end else if (lastWord) begin
          nextStatus = KEY_OK;
          nextState  = S_DONE;
        end else begin
          strobe.nextWord = 1'b1;
          nextState       = S_PEEK;
        end
      end
      S_PROG: begin
        fuseCmdValid      = 1'b1;
        fuseCmdWrite      = 1'b1;
        fuseCmdSingle     = 1'b1;
        strobe.startTimer = 1'b1;
        nextState         = S_PROG_WAIT;
      end
      S_PROG_WAIT: begin
        if (fuseRspValid) begin
          if (fuseRspError || fuseRspVerifyFail) begin
            nextStatus = KEY_FAIL;
            nextState  = S_DONE;
          end else if (lastWord) begin
            nextStatus = KEY_OK;
            nextState  = S_DONE;
          end else begin
            strobe.nextWord = 1'b1;
            nextState       = S_PEEK;
          end
        end else if (timedOut) begin
          nextStatus = KEY_TIMEOUT;
          nextState  = S_DONE;
        end
      end
      S_DONE: begin
        keyDone         = 1'b1;
        strobe.clearBuf = 1'b1;
        nextState       = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign keyGrant  = (state != S_IDLE);
  assign keyStatus = statusQ;
endmodule

// File: rtl/huk_provisioner.sv
module huk_provisioner
  import huk_pkg::*;
#(
  parameter int                 IDX_W          = 10,
  parameter logic [IDX_W-1:0]   SLOT_BASE      = 10'h104,
  parameter int                 WORDS          = 4,
  parameter int                 WORD_W         = 32,
  parameter int                 TIMEOUT_CYCLES = 1000
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            keyReq,
  output logic                            keyGrant,
  output logic                            keyDone,
  output logic [1:0]                      keyStatus,
  output logic [WORDS*WORD_W-1:0]         keyData,
  output logic                            rngReq,
  input  logic                            rngValid,
  input  logic [WORDS*WORD_W-1:0]         rngData,
  output logic                            fuseCmdValid,
  output logic                            fuseCmdWrite,
  output logic [IDX_W-1:0]                fuseCmdIndex,
  output logic [$clog2(WORDS+1)-1:0]      fuseCmdCount,
  output logic [WORD_W-1:0]               fuseCmdWdata,
  input  logic                            fuseRspValid,
  input  logic                            fuseRspError,
  input  logic                            fuseRspVerifyFail,
  input  logic [WORDS*WORD_W-1:0]         fuseRspData
);
  localparam int KEY_W    = WORDS * WORD_W;
  localparam int IDX_BITS = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CNT_W    = $clog2(WORDS + 1);

  hukStrobe_t          strobe;
  keyStatus_t          statusQ;
  logic [KEY_W-1:0]    keyBuf;
  logic [IDX_BITS-1:0] wordIdx;
  logic [WORD_W-1:0]   progBits;
  logic blank, conflict, noChange, lastWord, timedOut, cmdSingle;

  huk_control ctrl (
    .clk, .rstN, .keyReq, .fuseRspValid, .fuseRspError, .fuseRspVerifyFail,
    .rngValid, .blank, .conflict, .noChange, .lastWord, .timedOut,
    .strobe, .fuseCmdValid, .fuseCmdWrite, .fuseCmdSingle(cmdSingle),
    .rngReq, .keyGrant, .keyDone, .keyStatus(statusQ)
  );

  huk_datapath #(.WORDS(WORDS), .WORD_W(WORD_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) dp (
    .clk, .rstN, .strobe, .fuseRspData, .rngData, .keyBuf, .wordIdx,
    .progBits, .blank, .conflict, .noChange, .lastWord, .timedOut
  );

  assign keyStatus    = statusQ;
  assign keyData      = (keyDone && statusQ == KEY_OK) ? keyBuf : '0;
  assign fuseCmdIndex = cmdSingle ? SLOT_BASE + IDX_W'(wordIdx) : SLOT_BASE;
  assign fuseCmdCount = cmdSingle ? CNT_W'(1) : CNT_W'(WORDS);
  assign fuseCmdWdata = fuseCmdWrite ? progBits : '0;
endmodule

// File: rtl/huk_checks.sv
module huk_checks #(
  parameter int               IDX_W     = 10,
  parameter logic [IDX_W-1:0] SLOT_BASE = 10'h104,
  parameter int               WORDS     = 4,
  parameter int               WORD_W    = 32
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       keyReq,
  input logic                       keyGrant,
  input logic                       keyDone,
  input logic [1:0]                 keyStatus,
  input logic [WORDS*WORD_W-1:0]    keyData,
  input logic                       rngReq,
  input logic                       fuseCmdValid,
  input logic                       fuseCmdWrite,
  input logic [IDX_W-1:0]           fuseCmdIndex,
  input logic [$clog2(WORDS+1)-1:0] fuseCmdCount,
  input logic [WORD_W-1:0]          fuseCmdWdata
);
  assert_key_hidden_R9: assert property (@(posedge clk) disable iff (!rstN)
    !keyDone |-> keyData == '0);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    keyDone |=> !keyDone);
  assert_grant_gap_R10: assert property (@(posedge clk) disable iff (!rstN)
    keyDone |=> !keyGrant);
  assert_grant_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keyGrant) |-> $past(keyReq));
  assert_cmd_in_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    fuseCmdValid |-> keyGrant);
  assert_write_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fuseCmdValid && fuseCmdWrite) |-> (fuseCmdWdata != '0 && fuseCmdCount == 1));
  assert_write_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fuseCmdValid && fuseCmdWrite) |->
      (fuseCmdIndex >= SLOT_BASE && fuseCmdIndex < SLOT_BASE + IDX_W'(WORDS)));
  assert_rng_in_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    rngReq |-> (keyGrant && !fuseCmdValid));
  assert_status_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    keyDone |-> keyStatus != 2'd3);
endmodule

bind huk_provisioner huk_checks #(.IDX_W(IDX_W), .SLOT_BASE(SLOT_BASE), .WORDS(WORDS), .WORD_W(WORD_W)) chk (
  .clk(clk), .rstN(rstN), .keyReq(keyReq), .keyGrant(keyGrant), .keyDone(keyDone),
  .keyStatus(keyStatus), .keyData(keyData), .rngReq(rngReq), .fuseCmdValid(fuseCmdValid),
  .fuseCmdWrite(fuseCmdWrite), .fuseCmdIndex(fuseCmdIndex), .fuseCmdCount(fuseCmdCount),
  .fuseCmdWdata(fuseCmdWdata)
);

// File: tb/huk_provisioner_test.sv
module huk_provisioner_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 8;
  localparam logic [9:0] BASE = 10'h104;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyReq = 1'b0;
  logic keyGrant, keyDone, rngReq, fuseCmdValid, fuseCmdWrite;
  logic [1:0] keyStatus;
  logic [127:0] keyData;
  logic rngValid = 1'b0;
  logic [127:0] rngData = '0;
  logic [9:0] fuseCmdIndex;
  logic [2:0] fuseCmdCount;
  logic [31:0] fuseCmdWdata;
  logic fuseRspValid = 1'b0, fuseRspError = 1'b0, fuseRspVerifyFail = 1'b0;
  logic [127:0] fuseRspData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  huk_provisioner #(.TIMEOUT_CYCLES(TMO)) uut (
    .clk, .rstN, .keyReq, .keyGrant, .keyDone, .keyStatus, .keyData,
    .rngReq, .rngValid, .rngData, .fuseCmdValid, .fuseCmdWrite, .fuseCmdIndex,
    .fuseCmdCount, .fuseCmdWdata, .fuseRspValid, .fuseRspError,
    .fuseRspVerifyFail, .fuseRspData
  );

  int checks = 0;
  int fails  = 0;

  // behavioural fuse array, random source and command log
  logic [31:0] fz [4];
  logic [127:0] rngVal;
  int cmdN, wrCount, rngCount;
  logic cmdWr [16];
  logic [9:0] cmdIdx [16];
  logic [2:0] cmdCnt [16];
  logic [9:0] wrIdx [16];
  logic [31:0] wrData [16];
  int errAt, verifyAt, dropAt, slowAt, slowDelay, allDelay, mutIdx;
  logic [31:0] mutVal;
  int pend = 0;
  logic [127:0] pData;
  logic pErr, pVer;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearKnobs();
    errAt = -1; verifyAt = -1; dropAt = -1; slowAt = -1; slowDelay = 0;
    allDelay = 0; mutIdx = -1; mutVal = '0;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (!keyDone && keyData !== '0) begin
        fails++;
        $display("FAIL R9 keyData outside done actual=%h expected=0", keyData);
      end
    end
    fuseRspValid = 1'b0; fuseRspError = 1'b0; fuseRspVerifyFail = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        fuseRspValid = 1'b1; fuseRspError = pErr;
        fuseRspVerifyFail = pVer; fuseRspData = pData;
      end
    end
    if (rngValid) rngValid = 1'b0;
    else if (rngReq) begin
      rngValid = 1'b1; rngData = rngVal; rngCount++;
    end
    if (fuseCmdValid) begin
      int w;
      w = int'(fuseCmdIndex) - int'(BASE);
      if (cmdN < 16) begin
        cmdWr[cmdN] = fuseCmdWrite; cmdIdx[cmdN] = fuseCmdIndex; cmdCnt[cmdN] = fuseCmdCount;
      end
      pErr = (cmdN == errAt);
      pVer = (cmdN == verifyAt);
      pData = '0;
      if (!fuseCmdWrite) begin
        if (fuseCmdCount == 3'd4) pData = {fz[3], fz[2], fz[1], fz[0]};
        else if (w >= 0 && w < 4) pData = {96'b0, fz[w]};
      end else if (!pErr && !pVer && cmdN != dropAt && w >= 0 && w < 4) begin
        fz[w] = fz[w] | fuseCmdWdata;
        if (wrCount < 16) begin
          wrIdx[wrCount] = fuseCmdIndex; wrData[wrCount] = fuseCmdWdata;
        end
        wrCount++;
      end
      if (cmdN == 0 && mutIdx >= 0) fz[mutIdx] = mutVal;
      if (cmdN != dropAt) pend = ((cmdN == slowAt) ? slowDelay : allDelay) + 1;
      cmdN++;
    end
  end

  logic [1:0] st;
  logic [127:0] kd;

  task automatic doReq(input logic holdAfter);
    @(negedge clk);
    cmdN = 0; wrCount = 0; rngCount = 0;
    keyReq = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (keyDone) break;
    end
    st = keyStatus; kd = keyData;
    if (!keyDone) chk("R8 request never completed", 1, 0);
    if (!holdAfter) keyReq = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setSlot(input logic [127:0] v);
    for (int i = 0; i < 4; i++) fz[i] = v[i*32 +: 32];
  endtask

  localparam logic [127:0] RV = {32'hA5A50F0F, 32'h12345678, 32'h0, 32'hDEADBEEF};
  localparam logic [127:0] PV = {32'h0BAD_F00D, 32'h0, 32'h1111_2222, 32'h8000_0001};

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clearKnobs(); rngVal = RV; setSlot('0);
    cmdN = 0; wrCount = 0; rngCount = 0;
    idle(5);
    // R1 reset state
    chk("R1 grant", keyGrant, 0); chk("R1 done", keyDone, 0);
    chk("R1 cmd", fuseCmdValid, 0); chk("R1 rng", rngReq, 0); chk("R1 key", keyData, 0);
    rstN = 1'b1;
    idle(2);
    chk("R1 grant after reset", keyGrant, 0);

    // R2 R3: programmed slot returned as is
    setSlot(PV); clearKnobs();
    doReq(0);
    chk("R3 status", st, 0); chk("R3 key", kd, PV);
    chk("R3 no rng", rngCount, 0); chk("R3 no write", wrCount, 0);
    chk("R2 first cmd read", cmdWr[0], 0); chk("R2 first index", cmdIdx[0], BASE);
    chk("R2 first count", cmdCnt[0], 4);
    idle(12);

    // R4 R5 R8: blank slot, zero word skipped, timer restarts each command
    setSlot('0); clearKnobs(); allDelay = 6;
    doReq(0);
    chk("R4 status", st, 0); chk("R4 key", kd, RV); chk("R4 rng once", rngCount, 1);
    chk("R5 writes", wrCount, 3);
    chk("R4 peek count", cmdCnt[1], 1); chk("R4 peek read", cmdWr[1], 0);
    chk("R4 wr0 idx", wrIdx[0], BASE);        chk("R4 wr0 data", wrData[0], 32'hDEADBEEF);
    chk("R5 wr1 idx", wrIdx[1], BASE + 10'd2); chk("R4 wr1 data", wrData[1], 32'h12345678);
    chk("R4 wr2 idx", wrIdx[2], BASE + 10'd3); chk("R4 wr2 data", wrData[2], 32'hA5A50F0F);
    chk("R4 slot", {fz[3], fz[2], fz[1], fz[0]}, RV);
    idle(12);

    // R3 second request reads back the provisioned key
    clearKnobs();
    doReq(0);
    chk("R3 reuse status", st, 0); chk("R3 reuse key", kd, RV); chk("R3 reuse no rng", rngCount, 0);
    idle(12);

    // R5 partially set word: only missing bits are written
    setSlot('0); clearKnobs(); mutIdx = 2; mutVal = 32'h0000_5678;
    doReq(0);
    chk("R5 partial status", st, 0); chk("R5 partial writes", wrCount, 3);
    chk("R5 partial data", wrData[1], 32'h1234_0000);
    chk("R5 partial slot", {fz[3], fz[2], fz[1], fz[0]}, RV);
    idle(12);

    // R6 conflicting word aborts
    setSlot('0); clearKnobs(); mutIdx = 2; mutVal = 32'hFFFF_0000;
    doReq(0);
    chk("R6 status", st, 1); chk("R6 cmds", cmdN, 5); chk("R6 writes", wrCount, 1);
    chk("R6 untouched", fz[3], 0); chk("R9 key on fail", kd, 0);
    idle(12);

    // R7 error on burst read
    setSlot(PV); clearKnobs(); errAt = 0;
    doReq(0);
    chk("R7 read err status", st, 1); chk("R7 read err cmds", cmdN, 1); chk("R9 key on err", kd, 0);
    idle(12);

    // R7 verify failure on first write
    setSlot('0); clearKnobs(); verifyAt = 2;
    doReq(0);
    chk("R7 verify status", st, 1); chk("R7 verify cmds", cmdN, 3); chk("R7 verify slot", fz[0], 0);
    idle(12);

    // R8 dropped burst response
    setSlot(PV); clearKnobs(); dropAt = 0;
    doReq(0);
    chk("R8 timeout status", st, 2); chk("R8 timeout cmds", cmdN, 1); chk("R9 key on timeout", kd, 0);
    idle(12);

    // R8 response in last allowed cycle accepted, one later rejected
    setSlot(PV); clearKnobs(); slowAt = 0; slowDelay = TMO - 1;
    doReq(0);
    chk("R8 last cycle status", st, 0); chk("R8 last cycle key", kd, PV);
    idle(12);
    clearKnobs(); slowAt = 0; slowDelay = TMO;
    doReq(0);
    chk("R8 late status", st, 2);
    idle(12);

    // R8 dropped write response
    setSlot('0); clearKnobs(); dropAt = 2;
    doReq(0);
    chk("R8 write timeout status", st, 2); chk("R8 write timeout cmds", cmdN, 3);
    idle(12);

    // R10 request held high: gap, then served again; R9 done lasts one cycle
    setSlot(PV); clearKnobs();
    doReq(1);
    chk("R10 first status", st, 0);
    @(negedge clk);
    chk("R9 done one cycle", keyDone, 0);
    chk("R10 grant gap", keyGrant, 0);
    @(negedge clk);
    chk("R10 regrant", keyGrant, 1);
    for (int c = 0; c < 100; c++) begin
      if (keyDone) break;
      if (!keyGrant) chk("R10 grant held", keyGrant, 1);
      @(negedge clk);
    end
    chk("R10 second done", keyDone, 1); chk("R10 second key", keyData, PV);
    keyReq = 1'b0;
    idle(4);
    chk("R10 idle after", keyGrant, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule